// File: doc/BRIEF.md
# Level-Priority Interrupt Controller with Auto-Masking

This block gathers a set of level-sensitive interrupt request lines. Each line has a 3-bit priority held in its own control register. Every cycle the controller picks the strongest pending request and presents it to the processor as an encoded level and a source index. Level zero disables a source. When two eligible sources share a level, the one with the larger index wins. A request is eligible only when its level is strictly above the current level mask.

The processor acknowledges with a one-cycle strobe, and the controller returns the index it granted. When the auto-mask configuration bit is set, an acknowledge copies the current mask into the saved mask. It then raises the current mask to the acknowledged level, which holds off that level and every level below it until software lowers the mask again. The controller never clears a request: a source stays pending until its own line drops.

Software reaches the level registers, the configuration bit and both masks through a small synchronous register port. Read data is registered.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: After reset all source levels read 0, the configuration register reads 0, the current mask reads 0, the saved mask reads 8'h0F, and irq_level, irq_src and ack_src are all 0.
- R2: Addresses 0..N_SRC-1 hold the per-source level registers. A write stores wdata[2:0], and a read returns {5'b0, level}. reg_rdata shows the register at reg_addr one clock after the address is applied.
- R3: A source whose level is 0 never appears on the outputs, even while its request is asserted.
- R4: Among eligible requests, the highest level wins. irq_level carries that level and irq_src carries the winning index.
- R5: Among eligible requests of equal level, the larger source index wins.
- R6: The current mask sits at address N_SRC+1, in bits [3:0], with bits [7:4] reading 0. A request is eligible only when {1'b0,level} > current mask, so a mask of 7 or more blocks everything.
- R7: Address N_SRC bit 0 is the auto-mask enable. While it is 1, an ack seen while irq_level is nonzero copies the current mask into the saved mask (address N_SRC+2, bits [3:0]) and loads irq_level into the current mask.
- R8: While the auto-mask enable is 0, an ack changes neither the current mask nor the saved mask.
- R9: A register write to either mask in the same cycle as an ack cancels the whole auto-mask update. Only the written mask changes, and it takes the written value.
- R10: irq_level and irq_src reflect requests, levels and mask one clock after they change.
- R11: On ack, ack_src takes the value irq_src had on that cycle, one clock later, and holds it until the next ack. The acknowledge does not clear the request.
- R12: When no request is eligible, irq_level and irq_src are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | N_SRC | Level-sensitive request lines |
| irq_ack | input | 1 | One-cycle acknowledge strobe from the processor |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data for reg_addr |
| irq_level | output | 3 | Level of the winning request, 0 if none |
| irq_src | output | IDX_W | Index of the winning request |
| ack_src | output | IDX_W | Index granted by the last acknowledge |

## Verification
The arbitration outputs are due one clock after a change on the request lines. A mask or level write adds one more edge, because the register updates first and the arbiter sees it on the following edge. Inputs are driven on the falling edge. The one-clock checks (R10, ack_src, reg_rdata) sample at the very next falling edge. Every other output check waits two falling edges after the last stimulus, so it always compares against settled state. Expected values come from a bench model of the level table and the masks, which is updated whenever a write or an acknowledge is committed.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int LVL_W  = 3;
  localparam int MASK_W = 4;
  localparam int REG_W  = 8;
  typedef logic [LVL_W-1:0]  lvl_t;
  typedef logic [MASK_W-1:0] mask_t;
  localparam mask_t SAVED_RST = 4'hF;
  localparam mask_t CUR_RST   = 4'h0;
endpackage

// File: rtl/irq_lvl_regs.sv
module irq_lvl_regs
  import irq_pkg::*;
#(
  parameter int N_SRC = 64,
  localparam int IDX_W = $clog2(N_SRC)
)(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_idx,
  input  lvl_t                  wr_lvl,
  input  logic [IDX_W-1:0]      rd_idx,
  output lvl_t                  rd_lvl,
  output lvl_t [N_SRC-1:0]      lvls
);
  lvl_t [N_SRC-1:0] tbl;

  always_ff @(posedge clk) begin
    if (rst) tbl <= '0;
    else if (wr_en) tbl[wr_idx] <= wr_lvl;
  end

  assign lvls   = tbl;
  assign rd_lvl = tbl[rd_idx];

  // R2
  lvl_write_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> lvls[$past(wr_idx)] == $past(wr_lvl));
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int N_SRC = 64,
  localparam int IDX_W = $clog2(N_SRC)
)(
  input  logic [N_SRC-1:0]      req,
  input  lvl_t [N_SRC-1:0]      lvls,
  input  mask_t                 cur_mask,
  output lvl_t                  win_lvl,
  output logic [IDX_W-1:0]      win_idx
);
  logic [N_SRC-1:0] elig;

  for (genvar g = 0; g < N_SRC; g++) begin : g_elig
    assign elig[g] = req[g] && ({1'b0, lvls[g]} > cur_mask);
  end

  always_comb begin
    win_lvl = '0;
    win_idx = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (elig[i] && (lvls[i] >= win_lvl)) begin
        win_lvl = lvls[i];
        win_idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_mask_unit.sv
module irq_mask_unit
  import irq_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  ack,
  input  logic  auto_en,
  input  lvl_t  ack_lvl,
  input  logic  wr_cur,
  input  logic  wr_sav,
  input  mask_t wr_val,
  output mask_t cur_mask,
  output mask_t sav_mask
);
  logic auto_hit;
  assign auto_hit = ack && auto_en && (ack_lvl != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_mask <= CUR_RST;
      sav_mask <= SAVED_RST;
    end else if (wr_cur || wr_sav) begin
      if (wr_cur) cur_mask <= wr_val;
      if (wr_sav) sav_mask <= wr_val;
    end else if (auto_hit) begin
      sav_mask <= cur_mask;
      cur_mask <= {1'b0, ack_lvl};
    end
  end

  // R7
  auto_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (ack && auto_en && ack_lvl != '0 && !wr_cur && !wr_sav)
      |=> (cur_mask == {1'b0, $past(ack_lvl)}) && (sav_mask == $past(cur_mask)));
  // R8
  no_auto_chk: assert property (@(posedge clk) disable iff (rst)
    (ack && !auto_en && !wr_cur && !wr_sav) |=> $stable(cur_mask) && $stable(sav_mask));
  // R9
  wr_override_chk: assert property (@(posedge clk) disable iff (rst)
    (ack && wr_cur) |=> cur_mask == $past(wr_val));
endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl
  import irq_pkg::*;
#(
  parameter int N_SRC = 64,
  localparam int IDX_W  = $clog2(N_SRC),
  localparam int ADDR_W = IDX_W + 1
)(
  input  logic              clk,
  input  logic              rst,
  input  logic [N_SRC-1:0]  irq_req,
  input  logic              irq_ack,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic [2:0]        irq_level,
  output logic [IDX_W-1:0]  irq_src,
  output logic [IDX_W-1:0]  ack_src
);
  localparam logic [ADDR_W-1:0] A_CFG = ADDR_W'(N_SRC);
  localparam logic [ADDR_W-1:0] A_CUR = ADDR_W'(N_SRC + 1);
  localparam logic [ADDR_W-1:0] A_SAV = ADDR_W'(N_SRC + 2);

  logic              is_lvl, cfg_en;
  lvl_t              rd_lvl, win_lvl;
  lvl_t [N_SRC-1:0]  lvls;
  logic [IDX_W-1:0]  win_idx;
  mask_t             cur_mask, sav_mask;

  assign is_lvl = reg_addr < ADDR_W'(N_SRC);

  irq_lvl_regs #(.N_SRC(N_SRC)) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(reg_wr && is_lvl), .wr_idx(reg_addr[IDX_W-1:0]), .wr_lvl(reg_wdata[LVL_W-1:0]),
    .rd_idx(reg_addr[IDX_W-1:0]), .rd_lvl(rd_lvl), .lvls(lvls)
  );

  irq_arbiter #(.N_SRC(N_SRC)) u_arb (
    .req(irq_req), .lvls(lvls), .cur_mask(cur_mask),
    .win_lvl(win_lvl), .win_idx(win_idx)
  );

  irq_mask_unit u_mask (
    .clk(clk), .rst(rst), .ack(irq_ack), .auto_en(cfg_en), .ack_lvl(irq_level),
    .wr_cur(reg_wr && reg_addr == A_CUR), .wr_sav(reg_wr && reg_addr == A_SAV),
    .wr_val(reg_wdata[MASK_W-1:0]), .cur_mask(cur_mask), .sav_mask(sav_mask)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_en    <= 1'b0;
      irq_level <= '0;
      irq_src   <= '0;
      ack_src   <= '0;
      reg_rdata <= '0;
    end else begin
      if (reg_wr && reg_addr == A_CFG) cfg_en <= reg_wdata[0];
      irq_level <= win_lvl;
      irq_src   <= win_idx;
      if (irq_ack) ack_src <= irq_src;
      if (is_lvl)                 reg_rdata <= {5'b0, rd_lvl};
      else if (reg_addr == A_CFG) reg_rdata <= {7'b0, cfg_en};
      else if (reg_addr == A_CUR) reg_rdata <= {4'b0, cur_mask};
      else if (reg_addr == A_SAV) reg_rdata <= {4'b0, sav_mask};
      else                        reg_rdata <= '0;
    end
  end

  // R6
  mask_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_level != '0) |-> ({1'b0, irq_level} > $past(cur_mask)));
  // R12
  idle_src_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_level == '0) |-> (irq_src == '0));
  // R11
  ack_capture_chk: assert property (@(posedge clk) disable iff (rst)
    irq_ack |=> ack_src == $past(irq_src));
endmodule

// File: tb/tb_lvl_irq_ctrl.sv
`timescale 1ns/1ps
module tb_lvl_irq_ctrl;
  localparam int N = 64;
  localparam int IW = 6;
  localparam int AW = 7;

  logic clk = 0, rst = 1;
  logic [N-1:0] irq_req = '0;
  logic irq_ack = 0, reg_wr = 0;
  logic [AW-1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic [2:0] irq_level;
  logic [IW-1:0] irq_src, ack_src;

  lvl_irq_ctrl #(.N_SRC(N)) dut (.*);

  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [2:0] m_lvl [N];
  logic [3:0] m_cur = 4'h0, m_sav = 4'hF;
  bit m_en = 0;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic void model(output int lv, output int ix);
    lv = 0; ix = 0;
    for (int i = 0; i < N; i++)
      if (irq_req[i] && {1'b0, m_lvl[i]} > m_cur && int'(m_lvl[i]) >= lv) begin
        lv = m_lvl[i]; ix = i;
      end
  endfunction

  task automatic wr(int a, int d);
    @(negedge clk);
    reg_wr = 1; reg_addr = AW'(a); reg_wdata = 8'(d);
    @(negedge clk);
    reg_wr = 0;
    if (a < N) m_lvl[a] = 3'(d);
    else if (a == N) m_en = d[0];
    else if (a == N+1) m_cur = 4'(d);
    else if (a == N+2) m_sav = 4'(d);
  endtask

  task automatic rd_chk(string tag, int a, int exp);
    @(negedge clk);
    reg_addr = AW'(a);
    @(negedge clk);
    chk(tag, reg_rdata, exp);
  endtask

  task automatic out_chk(string tag);
    int lv, ix;
    repeat (2) @(negedge clk);
    model(lv, ix);
    chk({tag, " level"}, irq_level, lv);
    chk({tag, " src"}, irq_src, ix);
  endtask

  task automatic do_ack(string tag);
    int lv, ix;
    model(lv, ix);
    @(negedge clk);
    irq_ack = 1;
    @(negedge clk);
    irq_ack = 0;
    chk({tag, " ack_src"}, ack_src, ix);
    if (m_en && lv != 0) begin m_sav = m_cur; m_cur = 4'(lv); end
  endtask

  initial begin
    int lv, ix, seed;
    for (int i = 0; i < N; i++) m_lvl[i] = 0;
    seed = $urandom(32'd20240611);
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R1
    chk("R1 level", irq_level, 0);
    chk("R1 src", irq_src, 0);
    chk("R1 ack_src", ack_src, 0);
    rd_chk("R1 cfg", N, 0);
    rd_chk("R1 cur", N+1, 0);
    rd_chk("R1 sav", N+2, 8'h0F);
    rd_chk("R1 lvl9", 9, 0);
    // R2
    wr(7, 8'hFF);
    rd_chk("R2 reserved bits", 7, 7);
    wr(7, 0);
    // R3, R12
    irq_req = '1;
    out_chk("R3 all level0");
    chk("R12 none", irq_level, 0);
    // R4
    wr(5, 3); wr(40, 6); wr(10, 2);
    out_chk("R4 highest");
    chk("R4 idx40", irq_src, 40);
    // R5
    wr(63, 6);
    out_chk("R5 tie 63");
    chk("R5 idx63", irq_src, 63);
    wr(2, 4); wr(1, 4);
    @(negedge clk); irq_req = '0; irq_req[1] = 1; irq_req[2] = 1;
    out_chk("R5 tie 2 vs 1");
    chk("R5 idx2", irq_src, 2);
    // R10: one clock latency
    @(negedge clk); irq_req = '0; irq_req[10] = 1;
    @(negedge clk);
    chk("R10 level", irq_level, 2);
    chk("R10 src", irq_src, 10);
    // R6
    irq_req = '1;
    wr(N+1, 8'hF3);
    rd_chk("R6 cur readback", N+1, 3);
    out_chk("R6 mask3");
    wr(N+1, 6);
    out_chk("R6 mask6");
    chk("R6 blocked", irq_level, 0);
    wr(N+1, 0);
    // R8, R11
    out_chk("R8 pre");
    do_ack("R11");
    rd_chk("R8 cur", N+1, 0);
    rd_chk("R8 sav", N+2, 15);
    out_chk("R11 still pending");
    chk("R11 level6", irq_level, 6);
    // R7
    wr(N, 1);
    irq_req = '0; irq_req[5] = 1; irq_req[63] = 1;
    out_chk("R7 pre");
    do_ack("R7");
    rd_chk("R7 cur", N+1, 6);
    rd_chk("R7 sav", N+2, 0);
    out_chk("R7 masked");
    chk("R7 blocked", irq_level, 0);
    // R9
    wr(N+1, 2);
    out_chk("R9 pre");
    @(negedge clk);
    irq_ack = 1; reg_wr = 1; reg_addr = AW'(N+1); reg_wdata = 8'd1;
    @(negedge clk);
    irq_ack = 0; reg_wr = 0; m_cur = 1;
    rd_chk("R9 cur", N+1, 1);
    rd_chk("R9 sav", N+2, 0);
    // random mix
    for (int it = 0; it < 400; it++) begin
      int r;
      @(negedge clk);
      irq_req = {$urandom, $urandom};
      r = $urandom % 8;
      if (r < 3) wr($urandom % N, $urandom % 256);
      else if (r == 3) wr(N+1, $urandom % 4);
      else if (r == 4) wr(N, $urandom % 2);
      out_chk("R4 R5 R6 random");
      if (r >= 5) begin
        do_ack("R7 R8 random");
        rd_chk("R7 R8 random cur", N+1, m_cur);
        rd_chk("R7 R8 random sav", N+2, m_sav);
      end
    end
    model(lv, ix);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule